// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Appender

This block sits in a byte-wide transmit path. It takes the payload bytes of a frame one per clock and passes each one to its output. When it sees the byte flagged as last, it adds the four-byte frame check sequence (the 32-bit Ethernet CRC) directly behind the payload. The output stream therefore carries payload followed by FCS, and its last flag marks the final FCS byte.

The CRC advances by one whole byte per clock through a combinational XOR network. The network works in the MSB-first form with polynomial 0x04C11DB7, and each input byte is bit-reversed on its way in. The register starts from all ones on the first byte of every frame. At the end of the frame the register is bit-reversed and complemented to give the FCS word.

For the four cycles in which the FCS bytes leave, the block lowers its ready output and accepts no input. A new frame can start on the very next cycle after that.

Top module: `fcs_append`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: A byte accepted while in_valid and in_ready are both high appears on out_data one clock later, with out_valid = 1 and out_last = 0.
- R3: After the last payload byte, the next four output cycles carry the FCS bytes back to back, least significant byte first. The FCS is the complement of the reflected CRC-32 (polynomial terms 0 1 2 4 5 7 8 10 11 12 16 22 23 26 32, reflected constant 0xEDB88320) taken over the payload bytes, starting from 0xFFFFFFFF.
- R4: out_last is 1 only on the fourth FCS byte of a frame, and never on a payload byte.
- R5: in_ready is 0 for exactly four cycles after a byte flagged in_last is accepted. Bytes offered in that window are dropped and produce no output.
- R6: A frame that starts on the first cycle in_ready returns high gets its own correct FCS, seeded afresh with all ones.
- R7: A frame holding the single byte 0x00 produces the wire bytes 00, 8D, EF, 02, D2.
- R8: A cycle with in_valid = 0 inside a frame produces no output byte and leaves the running CRC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input byte is offered |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Offered byte ends the frame |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | out_data holds a byte |
| out_data | output | 8 | Payload or FCS byte |
| out_last | output | 1 | Final FCS byte of the frame |

## Verification
A fault in the running CRC register stays hidden during the payload and shows up only in the four FCS bytes. An exhaustive sweep of every single-byte frame therefore catches wrong feedback bits, a wrong bit order or a wrong final inversion within five cycles of the frame start. A seed flag that is not restored shows up in the FCS of the next frame of any back-to-back pair. A fault in the emit index shows as FCS bytes in the wrong order, or as a misplaced last flag, on the very frame where it occurs. A fault in the ready logic shows as dropped bytes becoming extra output bytes within one cycle.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam int unsigned DEF_CRC_W  = 32;
    localparam int unsigned DEF_BYTE_W = 8;
    localparam logic [31:0] DEF_POLY   = 32'h04C1_1DB7;

    typedef enum logic {
        MODE_PAYLOAD = 1'b0,
        MODE_FCS     = 1'b1
    } mode_e;
endpackage

// File: rtl/fcs_crc_step.sv
module fcs_crc_step #(
    parameter int unsigned CRC_W  = 32,
    parameter int unsigned BYTE_W = 8,
    parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    // byte enters bit-reversed so its bit 0 is shifted in first
    logic [BYTE_W-1:0] rev;
    logic [CRC_W-1:0]  stage [BYTE_W+1];

    assign stage[0] = crc_in;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
        assign rev[i] = data_in[BYTE_W-1-i];
    end

    for (genvar i = 0; i < BYTE_W; i++) begin : g_shift
        logic fb;
        assign fb = stage[i][CRC_W-1] ^ rev[BYTE_W-1-i];
        assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/fcs_finalize.sv
module fcs_finalize #(
    parameter int unsigned CRC_W = 32
) (
    input  logic [CRC_W-1:0] crc_in,
    output logic [CRC_W-1:0] fcs_out
);
    for (genvar i = 0; i < CRC_W; i++) begin : g_bit
        assign fcs_out[i] = ~crc_in[CRC_W-1-i];
    end
endmodule

// File: rtl/fcs_append.sv
module fcs_append
    import fcs_pkg::*;
#(
    parameter int unsigned CRC_W  = DEF_CRC_W,
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    parameter logic [CRC_W-1:0] POLY = DEF_POLY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last
);
    localparam int unsigned FCS_BYTES = CRC_W / BYTE_W;
    localparam int unsigned IDX_W     = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FCS_BYTES - 1);
    localparam logic [CRC_W-1:0] SEED = '1;

    typedef struct packed {
        mode_e             mode;
        logic [CRC_W-1:0]  crc;
        logic              sof;
        logic [IDX_W-1:0]  idx;
        logic              ov;
        logic [BYTE_W-1:0] od;
        logic              ol;
    } state_t;

    state_t st_d, st_q;

    logic [CRC_W-1:0]  step_in;
    logic [CRC_W-1:0]  step_out;
    logic [CRC_W-1:0]  fcs_word;
    logic [BYTE_W-1:0] fcs_byte;

    assign step_in  = st_q.sof ? SEED : st_q.crc;
    assign fcs_byte = fcs_word[st_q.idx*BYTE_W +: BYTE_W];

    fcs_crc_step #(
        .CRC_W  (CRC_W),
        .BYTE_W (BYTE_W),
        .POLY   (POLY)
    ) u_step (
        .crc_in  (step_in),
        .data_in (in_data),
        .crc_out (step_out)
    );

    fcs_finalize #(
        .CRC_W (CRC_W)
    ) u_fin (
        .crc_in  (st_q.crc),
        .fcs_out (fcs_word)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        st_d.ol = 1'b0;
        unique case (st_q.mode)
            MODE_PAYLOAD: begin
                if (in_valid) begin
                    st_d.ov  = 1'b1;
                    st_d.od  = in_data;
                    st_d.crc = step_out;
                    st_d.sof = 1'b0;
                    if (in_last) begin
                        st_d.mode = MODE_FCS;
                        st_d.idx  = '0;
                    end
                end
            end
            MODE_FCS: begin
                st_d.ov  = 1'b1;
                st_d.od  = fcs_byte;
                st_d.idx = st_q.idx + 1'b1;
                if (st_q.idx == LAST_IDX) begin
                    st_d.ol   = 1'b1;
                    st_d.mode = MODE_PAYLOAD;
                    st_d.sof  = 1'b1;
                    st_d.idx  = '0;
                end
            end
            default: st_d.mode = MODE_PAYLOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= MODE_PAYLOAD;
            st_q.crc  <= SEED;
            st_q.sof  <= 1'b1;
            st_q.idx  <= '0;
            st_q.ov   <= 1'b0;
            st_q.od   <= '0;
            st_q.ol   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = (st_q.mode == MODE_PAYLOAD);
    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;
    assign out_last  = st_q.ol;
endmodule

// File: rtl/fcs_append_chk.sv
module fcs_append_chk #(
    parameter int unsigned CRC_W  = 32,
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [BYTE_W-1:0] in_data,
    input logic              in_last,
    input logic              in_ready,
    input logic              out_valid,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_last
);
    localparam int unsigned FCS_BYTES = CRC_W / BYTE_W;
    localparam int unsigned RUN_W     = $clog2(FCS_BYTES + 2);

    logic [RUN_W-1:0] stall_run_q;

    always_ff @(posedge clk) begin
        if (rst)            stall_run_q <= '0;
        else if (!in_ready) stall_run_q <= stall_run_q + 1'b1;
        else                stall_run_q <= '0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!out_valid && in_ready)); // R1
    AST_PAYLOAD_ECHO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && !out_last && out_data == $past(in_data))); // R2
    AST_STALL_EMITS: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> out_valid); // R3
    AST_LAST_AFTER_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> (in_ready && stall_run_q == RUN_W'(FCS_BYTES))); // R4
    AST_STALL_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> !in_ready); // R5
    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> (stall_run_q < RUN_W'(FCS_BYTES))); // R5
    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> !out_valid); // R8
endmodule

bind fcs_append fcs_append_chk #(
    .CRC_W  (CRC_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/fcs_append_tb.sv
module fcs_append_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [7:0] d;
        logic       l;
        int         tag;
    } exp_t;

    exp_t exp_q[$];
    logic [7:0] fbuf [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    fcs_append u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    function automatic string tag_name(input int t);
        case (t)
            2: return "R2";
            3: return "R3";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++)
            r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        return r;
    endfunction

    // output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R5 actual=extra byte %h expected=no output", out_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(tag_name(e.tag), {24'h0, out_data}, {24'h0, e.d});
                check("R4", {31'h0, out_last}, {31'h0, e.l});
            end
        end
    end

    // len bytes from fbuf; gaps inserts idle cycles; b2b starts without an idle cycle
    task automatic send_frame(input int len, input bit gaps, input bit b2b, input int ftag);
        logic [31:0] c;
        logic [31:0] fcs;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < len; k++) begin
            if (gaps && (k % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = 8'h5A;
                in_last  = 1'b1;
            end
            if (!(k == 0 && b2b)) @(negedge clk);
            in_valid = 1'b1;
            in_data  = fbuf[k];
            in_last  = (k == len - 1);
            exp_q.push_back('{d: fbuf[k], l: 1'b0, tag: 2});
            c = ref_step(c, fbuf[k]);
        end
        fcs = ~c;
        for (int j = 0; j < 4; j++)
            exp_q.push_back('{d: fcs[j*8 +: 8], l: (j == 3), tag: ftag});
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            check("R5", {31'h0, in_ready}, 32'h0);
            in_valid = 1'b1;
            in_data  = 8'hA5 ^ 8'(s);
            in_last  = s[0];
        end
        @(negedge clk);
        check("R5", {31'h0, in_ready}, 32'h1);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {31'h0, out_valid}, 32'h0);
        check("R1", {31'h0, in_ready}, 32'h1);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {31'h0, out_valid}, 32'h0);
        check("R1", {31'h0, in_ready}, 32'h1);

        // R7: single zero byte; expected wire bytes written out literally
        fbuf[0] = 8'h00;
        exp_q.push_back('{d: 8'h00, l: 1'b0, tag: 7});
        exp_q.push_back('{d: 8'h8D, l: 1'b0, tag: 7});
        exp_q.push_back('{d: 8'hEF, l: 1'b0, tag: 7});
        exp_q.push_back('{d: 8'h02, l: 1'b0, tag: 7});
        exp_q.push_back('{d: 8'hD2, l: 1'b1, tag: 7});
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h00;
        in_last  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (6) @(negedge clk);
        check("R7", exp_q.size(), 0);

        // R3: every single-byte frame, alternating idle start and back-to-back (R6)
        for (int v = 0; v < 256; v++) begin
            fbuf[0] = 8'(v);
            send_frame(1, 1'b0, v[0], v[0] ? 6 : 3);
        end

        // R3 / R6 / R8: multi-byte frames of varied length and content
        for (int len = 2; len <= 40; len++) begin
            for (int k = 0; k < len; k++)
                fbuf[k] = 8'((len * 37 + k * 11 + (k * k)) & 255);
            send_frame(len, len[1], len[0], len[1] ? 8 : (len[0] ? 6 : 3));
        end

        // long frame of all ones bytes, back-to-back
        for (int k = 0; k < 64; k++) fbuf[k] = 8'hFF;
        send_frame(64, 1'b0, 1'b1, 6);

        repeat (8) @(negedge clk);
        check("R5", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        done = 1'b1;
        $finish;
    end
endmodule